// File: doc/BRIEF.md
# Ping-Pong Ethernet Frame Receive Store

This block sits between a byte-wide receive stream and a processor. It takes frame bytes as they arrive, each qualified by a valid strobe, with a last strobe on the final byte. The stream has already been stripped of preamble and assembled into bytes. The block runs the Ethernet CRC-32 over every byte and writes the bytes into one of two equal receive banks. When the frame ends, it places a 16-bit length word at the start of that bank. Bit 15 of the length word flags a CRC failure.

Once the header is written, the block hands the filled bank over to the reader and starts the next frame in the other bank. A status output tells which bank was filled most recently. The processor picks the bank it reads through a separate select input, so it can read one frame while the next one is being written. A completion pulse fires for every frame. A second pulse fires only for frames whose check sequence is correct, and an interrupt controller can use it directly.

Top module: `eth_rx_dbuf`

## Requirements
- R1: After reset `wr_buf_o` is 1, `rx_done_o` and `rx_good_o` are 0, and the first frame goes to bank 0.
- R2: Byte k of a frame (k counted from 0, check sequence included) is stored at offset k+2 of the bank being filled.
- R3: Once a frame is complete, offset 0 of its bank holds length[7:0] and offset 1 holds {crc_fail, length[14:8]}. Here length is the number of bytes accepted, check sequence included.
- R4: The CRC uses the reflected polynomial 0xEDB88320 with an all-ones start value. Each byte is fed least significant bit first. A frame passes when the register equals 0xDEBB20E3 after its last byte. A failing frame sets bit 7 of offset 1.
- R5: `rx_done_o` is high for exactly one cycle, in the cycle after the third rising edge counted from the edge that accepts the last byte.
- R6: `rx_good_o` pulses together with `rx_done_o` only when the frame passes the CRC. It never pulses for a failing frame.
- R7: `wr_buf_o` changes only when `rx_done_o` rises, and it then names the bank just filled. Consecutive frames alternate between banks 0 and 1.
- R8: For a frame longer than BUF_BYTES-2 bytes, only the first BUF_BYTES-2 bytes are stored and the length is clamped to BUF_BYTES-2. The extra bytes overwrite nothing, the header included, but they still enter the CRC.
- R9: `rd_data_o` shows the byte at `rd_addr_i` of bank `rd_sel_i` one clock after those inputs are sampled. Filling one bank leaves the other bank's content unchanged.
- R10: Data and last strobe are ignored while `rx_valid_i` is low. `rx_valid_i` must stay low for the two cycles that follow a last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_data_i | input | 8 | Receive byte |
| rx_last_i | input | 1 | Marks the final byte of a frame |
| rd_sel_i | input | 1 | Bank shown on the read port |
| rd_addr_i | input | ADDR_W | Read byte offset within the bank |
| rd_data_o | output | 8 | Read byte, one cycle latency |
| wr_buf_o | output | 1 | Bank most recently filled |
| rx_done_o | output | 1 | One-cycle pulse per completed frame |
| rx_good_o | output | 1 | One-cycle pulse per CRC-passing frame |

## Verification
The checker assumes that the receive source leaves two idle cycles after each last byte, while the two header bytes are written. It flags any valid byte that arrives in that gap. The pulse-timing property also assumes that every accepted last byte starts a header sequence, and this holds only under the same gap rule. The bench drives each frame from a task that drops valid right after the last byte. It then waits through both header cycles before the next frame may start, and idle cycles inserted in the middle of a frame carry junk data and a raised last strobe with valid held low.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;
  localparam logic [31:0] CRC_POLY_R  = 32'hEDB8_8320;
  localparam logic [31:0] CRC_INIT    = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB_20E3;

  typedef enum logic [1:0] {
    ST_DATA   = 2'd0,
    ST_HDR_LO = 2'd1,
    ST_HDR_HI = 2'd2
  } rx_state_e;

  // one byte, LSB first, reflected register
  function automatic logic [31:0] crc32_step(input logic [31:0] crc, input logic [7:0] d);
    logic [31:0] c;
    c = crc;
    for (int b = 0; b < 8; b++) begin
      if (c[0] ^ d[b]) c = (c >> 1) ^ CRC_POLY_R;
      else             c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/eth_rx_crc.sv
module eth_rx_crc
  import eth_rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic [7:0] data_i,
  output logic       ok_o
);
  logic [31:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= CRC_INIT;
    else if (clr_i) crc_q <= CRC_INIT;
    else if (en_i)  crc_q <= crc32_step(crc_q, data_i);
  end

  assign ok_o = (crc_q == CRC_RESIDUE);
endmodule

// File: rtl/eth_rx_bank.sv
module eth_rx_bank #(
  parameter  int DEPTH  = 2048,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  logic [7:0] mem [DEPTH];
  logic [7:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/eth_rx_wctl.sv
module eth_rx_wctl
  import eth_rx_pkg::*;
#(
  parameter  int BUF_BYTES = 2048,
  localparam int ADDR_W    = $clog2(BUF_BYTES),
  localparam int MAX_LEN   = BUF_BYTES - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [7:0]        data_i,
  input  logic              last_i,
  input  logic              crc_ok_i,
  output logic              crc_clr_o,
  output logic              crc_en_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [7:0]        wdata_o,
  output logic              fill_o,
  output logic              wr_buf_o,
  output logic              done_o,
  output logic              good_o
);
  rx_state_e         state_q, state_d;
  logic [ADDR_W-1:0] cnt_q, cnt_d;
  logic              wr_buf_q, done_q, good_q;
  logic [15:0]       len16;
  logic              accept;

  assign len16  = 16'(cnt_q);
  assign accept = (state_q == ST_DATA) && valid_i;
  assign fill_o = ~wr_buf_q;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    we_o      = 1'b0;
    waddr_o   = '0;
    wdata_o   = data_i;
    crc_en_o  = 1'b0;
    crc_clr_o = 1'b0;
    unique case (state_q)
      ST_DATA: begin
        if (accept) begin
          crc_en_o = 1'b1;
          if (32'(cnt_q) < MAX_LEN) begin
            we_o    = 1'b1;
            waddr_o = cnt_q + ADDR_W'(2);
            cnt_d   = cnt_q + ADDR_W'(1);
          end
          if (last_i) state_d = ST_HDR_LO;
        end
      end
      ST_HDR_LO: begin
        we_o    = 1'b1;
        waddr_o = '0;
        wdata_o = len16[7:0];
        state_d = ST_HDR_HI;
      end
      ST_HDR_HI: begin
        we_o      = 1'b1;
        waddr_o   = ADDR_W'(1);
        wdata_o   = {~crc_ok_i, len16[14:8]};
        crc_clr_o = 1'b1;
        cnt_d     = '0;
        state_d   = ST_DATA;
      end
      default: state_d = ST_DATA;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_DATA;
      cnt_q    <= '0;
      wr_buf_q <= 1'b1;
      done_q   <= 1'b0;
      good_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= (state_q == ST_HDR_HI);
      good_q  <= (state_q == ST_HDR_HI) && crc_ok_i;
      if (state_q == ST_HDR_HI) wr_buf_q <= ~wr_buf_q;
    end
  end

  assign wr_buf_o = wr_buf_q;
  assign done_o   = done_q;
  assign good_o   = good_q;
endmodule

// File: rtl/eth_rx_dbuf.sv
module eth_rx_dbuf #(
  parameter  int BUF_BYTES = 2048,
  localparam int ADDR_W    = $clog2(BUF_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_last_i,
  input  logic              rd_sel_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              wr_buf_o,
  output logic              rx_done_o,
  output logic              rx_good_o
);
  localparam int N_BANKS = 2;

  logic              crc_clr, crc_en, crc_ok;
  logic              we, fill;
  logic [ADDR_W-1:0] waddr;
  logic [7:0]        wdata;
  logic [7:0]        bank_rdata [N_BANKS];
  logic              sel_q;

  eth_rx_crc i_crc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (crc_clr),
    .en_i   (crc_en),
    .data_i (rx_data_i),
    .ok_o   (crc_ok)
  );

  eth_rx_wctl #(.BUF_BYTES(BUF_BYTES)) i_wctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (rx_valid_i),
    .data_i    (rx_data_i),
    .last_i    (rx_last_i),
    .crc_ok_i  (crc_ok),
    .crc_clr_o (crc_clr),
    .crc_en_o  (crc_en),
    .we_o      (we),
    .waddr_o   (waddr),
    .wdata_o   (wdata),
    .fill_o    (fill),
    .wr_buf_o  (wr_buf_o),
    .done_o    (rx_done_o),
    .good_o    (rx_good_o)
  );

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    eth_rx_bank #(.DEPTH(BUF_BYTES)) i_bank (
      .clk_i   (clk_i),
      .we_i    (we && (fill == 1'(b))),
      .waddr_i (waddr),
      .wdata_i (wdata),
      .raddr_i (rd_addr_i),
      .rdata_o (bank_rdata[b])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= rd_sel_i;
  end

  assign rd_data_o = bank_rdata[sel_q];
endmodule

// File: rtl/eth_rx_dbuf_chk.sv
module eth_rx_dbuf_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_valid_i,
  input logic rx_last_i,
  input logic wr_buf_o,
  input logic rx_done_o,
  input logic rx_good_o
);
  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |=> !rx_done_o);

  a_r5_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rx_valid_i && rx_last_i, 3) |-> rx_done_o);

  a_r5_done_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |-> $past(rx_valid_i && rx_last_i, 3));

  a_r6_good_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_good_o |-> rx_done_o);

  a_r7_buf_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_done_o) |-> (wr_buf_o != $past(wr_buf_o)));

  a_r7_buf_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_done_o |-> $stable(wr_buf_o));

  a_r10_gap1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_last_i) |=> !rx_valid_i);

  a_r10_gap2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rx_valid_i && rx_last_i, 2) |-> !rx_valid_i);
endmodule

bind eth_rx_dbuf eth_rx_dbuf_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_valid_i (rx_valid_i),
  .rx_last_i  (rx_last_i),
  .wr_buf_o   (wr_buf_o),
  .rx_done_o  (rx_done_o),
  .rx_good_o  (rx_good_o)
);

// File: tb/test_eth_rx_dbuf.sv
module test_eth_rx_dbuf;
  localparam int BUF_BYTES = 64;
  localparam int AW        = $clog2(BUF_BYTES);
  localparam int MAXL      = BUF_BYTES - 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_data = '0;
  logic          rx_last = 1'b0;
  logic          rd_sel = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          wbuf, done, good;

  int n_chk = 0, n_fail = 0;
  logic [7:0] frm [256];
  logic       exp_buf = 1'b1;

  always #5 clk = ~clk;

  eth_rx_dbuf #(.BUF_BYTES(BUF_BYTES)) i_eth_rx_dbuf (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_last_i(rx_last), .rd_sel_i(rd_sel), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .wr_buf_o(wbuf), .rx_done_o(done), .rx_good_o(good)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++)
      for (int b = 0; b < 8; b++)
        c = (c[0] ^ frm[i][b]) ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    return c;
  endfunction

  // returns total length incl. 4-byte check sequence, FCS LSB first
  function automatic int build(input int n_pay, input int seed, input bit corrupt);
    logic [31:0] fcs;
    for (int i = 0; i < n_pay; i++) frm[i] = 8'(i * 37 + seed * 11 + 3);
    fcs = ~ref_crc(n_pay);
    for (int k = 0; k < 4; k++) frm[n_pay + k] = fcs[8*k +: 8];
    if (corrupt) frm[0] = frm[0] ^ 8'h10;
    return n_pay + 4;
  endfunction

  task automatic rd(input logic sel, input int addr, output logic [7:0] val);
    @(negedge clk);
    rd_sel  = sel;
    rd_addr = AW'(addr);
    @(posedge clk);
    @(negedge clk);
    val = rd_data;
  endtask

  task automatic send(input int n, input int gap, input bit exp_good);
    for (int i = 0; i < n; i++) begin
      if (gap > 0 && (i % gap) == gap - 1) begin
        @(negedge clk);
        rx_valid = 1'b0; rx_data = 8'hA5; rx_last = 1'b1; // R10 ignored junk
      end
      @(negedge clk);
      rx_valid = 1'b1; rx_data = frm[i]; rx_last = (i == n - 1);
    end
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    exp_buf = ~exp_buf;
    chk("R5 done pulse", 32'(done), 1);
    chk("R6 good flag", 32'(good), 32'(exp_good));
    chk("R7 wr_buf", 32'(wbuf), 32'(exp_buf));
    @(negedge clk);
    chk("R5 done one cycle", 32'(done), 0);
    chk("R6 good one cycle", 32'(good), 0);
  endtask

  task automatic check_bank(input logic b, input int n, input bit exp_good);
    logic [7:0] v;
    int len = (n > MAXL) ? MAXL : n;
    rd(b, 0, v);
    chk("R3 len lo", 32'(v), 32'(len & 8'hFF));
    rd(b, 1, v);
    chk("R3 R4 len hi/fail", 32'(v), 32'({~exp_good, 7'(len >> 8)}));
    for (int i = 0; i < len; i++) begin
      rd(b, i + 2, v);
      chk("R2 data", 32'(v), 32'(frm[i]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n, prev_len;
    bit prev_good;
    logic [7:0] v;
    repeat (3) @(negedge clk);
    chk("R1 wr_buf reset", 32'(wbuf), 1);
    chk("R1 done reset", 32'(done), 0);
    chk("R1 good reset", 32'(good), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // good frame into bank 0 (R1, R4)
    n = build(10, 1, 1'b0);
    send(n, 0, 1'b1);
    chk("R1 first bank", 32'(wbuf), 0);
    check_bank(1'b0, n, 1'b1);

    // bad CRC into bank 1 (R4, R6); bank 0 intact (R9)
    n = build(20, 2, 1'b1);
    send(n, 0, 1'b0);
    check_bank(1'b1, n, 1'b0);
    rd(1'b0, 0, v);
    chk("R9 other bank kept", 32'(v), 14);

    // sweep of lengths, alternating good/bad (R2 R3 R4 R7 R9)
    prev_len = n; prev_good = 1'b0;
    for (int p = 0; p <= MAXL - 4; p++) begin
      bit g = (p % 3) != 1;
      n = build(p, p + 5, !g);
      send(n, (p % 4 == 0) ? 3 : 0, g);
      check_bank(exp_buf, n, g);
      rd(~exp_buf, 0, v);
      chk("R9 other bank header", 32'(v), 32'(prev_len & 8'hFF));
      rd(~exp_buf, 1, v);
      chk("R9 other bank flag", 32'(v[7]), 32'(!prev_good));
      prev_len = n; prev_good = g;
    end

    // overflow: clamped length, CRC still over all bytes (R8)
    n = build(70, 9, 1'b0);
    send(n, 0, 1'b1);
    check_bank(exp_buf, n, 1'b1);
    rd(exp_buf, 0, v);
    chk("R8 clamp", 32'(v), MAXL);

    // overflow with bad CRC (R8 R4)
    n = build(80, 4, 1'b1);
    send(n, 5, 1'b0);
    check_bank(exp_buf, n, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule